// File: doc/BRIEF.md
# TLP Qword Packer with Alignment

This block turns one short transaction layer packet into a stream of 64-bit words for a root-port transmit register pair. A packet is given as three header dwords, an optional single payload dword, the packet's target address, a flag marking it as a configuration request, and a one-cycle start strobe. The block captures the request and then presents two or three 64-bit words on a valid/ready output, flagging the final one with last.

Where the payload dword sits depends on qword alignment of the target address. An aligned payload starts a fresh 64-bit word. The packet then takes three words, and the upper half of the header word before it is a zero filler that is still sent. An unaligned payload shares the second word with the last header dword. Configuration requests are held back until a link-active input reads 1.

Top module: `tlp_qw_packer`

## Requirements
- R1: The first word of every packet carries header dword 0 in bits [31:0] and header dword 1 in bits [63:32], with last low.
- R2: With a payload and address bit 2 equal to 1 (unaligned), the second word is {data, header dword 2} (data in [63:32]) with last high, and the packet has two words.
- R3: With a payload and address bit 2 equal to 0 (aligned), the second word is {32'h0, header dword 2} with last low, and a third word {32'h0, data} follows with last high.
- R4: Without a payload, the second word is {32'h0, header dword 2} with last high, whatever the address.
- R5: Only address bit 2 selects the layout. All other address bits have no effect on the words sent.
- R6: A configuration request (cfg flag 1) started while link-active is 0 produces no valid word until link-active is 1. Its first word appears in the cycle after link-active is seen high. Requests that are not configuration requests are not delayed by link-active.
- R7: While valid is high and ready is low, the output word and last stay unchanged and valid stays high.
- R8: A start pulse while a packet is held or being sent is ignored. The packet in progress completes unchanged, and no further packet follows it.
- R9: Reset clears valid by the next clock edge and returns the block to idle. Valid stays low in the first cycle after reset is released.
- R10: Last is high only together with valid. Valid is low in the cycle after the last word is accepted. The first word of a packet is valid in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe, sampled when idle |
| hdr0_i | input | 32 | Header dword 0 |
| hdr1_i | input | 32 | Header dword 1 |
| hdr2_i | input | 32 | Header dword 2 |
| has_data_i | input | 1 | 1 when the request carries a payload dword |
| data_i | input | 32 | Payload dword |
| addr_i | input | 32 | Packet target address; bit 2 gives qword alignment |
| is_cfg_i | input | 1 | 1 for a configuration request |
| link_up_i | input | 1 | Link-active status |
| ready_i | input | 1 | Downstream accepts the current word |
| out_data_o | output | 64 | Output word |
| out_valid_o | output | 1 | Output word is valid |
| out_last_o | output | 1 | Output word is the last of its packet |

## Verification
A beat counter stuck or skipped shows at the ports straight away. The word after the header word carries the wrong half, or last comes one word early or late, in the same cycle the faulty beat is presented. A sequencer left in the wrong state shows within one cycle: valid rises while a configuration request should be held, or stays high after the final accept. A capture register loaded at the wrong time shows as foreign header or payload values in the words of the packet in progress.

// File: rtl/tlpq_pkg.sv
package tlpq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_SEND = 2'd2
  } sq_state_e;

  // number of 64-bit beats for a given request shape
  function automatic logic [1:0] beat_count(input logic has_data, input logic aligned);
    return (has_data && aligned) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/tlpq_capture.sv
module tlpq_capture #(
  parameter int DW        = 32,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_BIT = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [DW-1:0] hdr0_i,
  input  logic [DW-1:0] hdr1_i,
  input  logic [DW-1:0] hdr2_i,
  input  logic [DW-1:0] data_i,
  input  logic          has_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DW-1:0] hdr0_o,
  output logic [DW-1:0] hdr1_o,
  output logic [DW-1:0] hdr2_o,
  output logic [DW-1:0] data_o,
  output logic          has_data_o,
  output logic          aligned_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hdr0_o     <= '0;
      hdr1_o     <= '0;
      hdr2_o     <= '0;
      data_o     <= '0;
      has_data_o <= 1'b0;
      aligned_o  <= 1'b0;
    end else if (load_i) begin
      hdr0_o     <= hdr0_i;
      hdr1_o     <= hdr1_i;
      hdr2_o     <= hdr2_i;
      data_o     <= data_i;
      has_data_o <= has_data_i;
      aligned_o  <= ~addr_i[ALIGN_BIT];
    end
  end
endmodule

// File: rtl/tlpq_layout.sv
module tlpq_layout #(
  parameter int DW     = 32,
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [DW-1:0]     hdr0_i,
  input  logic [DW-1:0]     hdr1_i,
  input  logic [DW-1:0]     hdr2_i,
  input  logic [DW-1:0]     data_i,
  input  logic              has_data_i,
  input  logic              aligned_i,
  output logic [2*DW-1:0]   word_o,
  output logic              last_o
);
  import tlpq_pkg::*;

  logic [DW-1:0] lo_half, hi_half;
  logic [1:0]    nbeats;

  always_comb begin
    lo_half = '0;
    hi_half = '0;
    case (beat_i)
      BEAT_W'(0): begin
        lo_half = hdr0_i;
        hi_half = hdr1_i;
      end
      BEAT_W'(1): begin
        lo_half = hdr2_i;
        hi_half = (has_data_i && !aligned_i) ? data_i : '0;
      end
      BEAT_W'(2): begin
        lo_half = data_i;
        hi_half = '0;
      end
      default: begin
        lo_half = '0;
        hi_half = '0;
      end
    endcase
  end

  assign nbeats = beat_count(has_data_i, aligned_i);
  assign word_o = {hi_half, lo_half};
  assign last_o = (beat_i == BEAT_W'(nbeats - 2'd1));
endmodule

// File: rtl/tlpq_seq.sv
module tlpq_seq #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              is_cfg_i,
  input  logic              link_up_i,
  input  logic              ready_i,
  input  logic              last_i,
  output logic              load_o,
  output tlpq_pkg::sq_state_e state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              valid_o
);
  import tlpq_pkg::*;

  sq_state_e         st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  assign load_o = (st_q == SQ_IDLE) && start_i;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          beat_d = '0;
          st_d   = (is_cfg_i && !link_up_i) ? SQ_HOLD : SQ_SEND;
        end
      end
      SQ_HOLD: begin
        if (link_up_i) st_d = SQ_SEND;
      end
      SQ_SEND: begin
        if (ready_i) begin
          if (last_i) st_d = SQ_IDLE;
          else        beat_d = beat_q + BEAT_W'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= SQ_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  assign state_o = st_q;
  assign beat_o  = beat_q;
  assign valid_o = (st_q == SQ_SEND);
endmodule

// File: rtl/tlp_qw_packer.sv
module tlp_qw_packer #(
  parameter int DW        = 32,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_BIT = 2,
  parameter int BEAT_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [DW-1:0]     hdr0_i,
  input  logic [DW-1:0]     hdr1_i,
  input  logic [DW-1:0]     hdr2_i,
  input  logic              has_data_i,
  input  logic [DW-1:0]     data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_cfg_i,
  input  logic              link_up_i,
  input  logic              ready_i,
  output logic [2*DW-1:0]   out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o
);
  import tlpq_pkg::*;

  logic              load;
  sq_state_e         seq_state;
  logic [BEAT_W-1:0] beat;
  logic              valid;
  logic [DW-1:0]     c_h0, c_h1, c_h2, c_data;
  logic              c_has_data, c_aligned;
  logic [2*DW-1:0]   word;
  logic              word_last;
  logic              holding;

  tlpq_capture #(.DW(DW), .ADDR_W(ADDR_W), .ALIGN_BIT(ALIGN_BIT)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load),
    .hdr0_i(hdr0_i), .hdr1_i(hdr1_i), .hdr2_i(hdr2_i), .data_i(data_i),
    .has_data_i(has_data_i), .addr_i(addr_i),
    .hdr0_o(c_h0), .hdr1_o(c_h1), .hdr2_o(c_h2), .data_o(c_data),
    .has_data_o(c_has_data), .aligned_o(c_aligned)
  );

  tlpq_layout #(.DW(DW), .BEAT_W(BEAT_W)) u_lay (
    .beat_i(beat), .hdr0_i(c_h0), .hdr1_i(c_h1), .hdr2_i(c_h2),
    .data_i(c_data), .has_data_i(c_has_data), .aligned_i(c_aligned),
    .word_o(word), .last_o(word_last)
  );

  tlpq_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .is_cfg_i(is_cfg_i),
    .link_up_i(link_up_i), .ready_i(ready_i), .last_i(word_last),
    .load_o(load), .state_o(seq_state), .beat_o(beat), .valid_o(valid)
  );

  assign holding     = (seq_state == SQ_HOLD);
  assign out_valid_o = valid;
  assign out_data_o  = valid ? word : '0;
  assign out_last_o  = valid & word_last;
endmodule

// File: rtl/tlpq_packer_chk.sv
module tlpq_packer_chk #(
  parameter int OW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          valid,
  input logic          last,
  input logic [OW-1:0] data,
  input logic          ready,
  input logic          link_up,
  input logic          hold
);
  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data) && $stable(last)));

  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last |-> valid);

  // R10
  end_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && last) |=> !valid);

  // R6
  held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !valid);

  // R6
  held_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !link_up) |=> !valid);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> !valid);
endmodule

bind tlp_qw_packer tlpq_packer_chk #(.OW(2*DW)) u_chk (
  .clk(clk_i), .rst(rst_i), .valid(out_valid_o), .last(out_last_o),
  .data(out_data_o), .ready(ready_i), .link_up(link_up_i), .hold(holding)
);

// File: tb/sim_tlp_qw_packer.sv
`timescale 1ns/1ps
module sim_tlp_qw_packer;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int VW = 1 + AW + 4*DW;
  localparam int NV = 6;

  // {has_data, addr, data, hdr2, hdr1, hdr0}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 32'h0000_1004, 32'hDDDD_0001, 32'h2222_0001, 32'h1111_0001, 32'h0000_0001},
    {1'b1, 32'h0000_1008, 32'hDDDD_0002, 32'h2222_0002, 32'h1111_0002, 32'h0000_0002},
    {1'b0, 32'h0000_2000, 32'hDDDD_0003, 32'h2222_0003, 32'h1111_0003, 32'h0000_0003},
    {1'b0, 32'h0000_2004, 32'hDDDD_0004, 32'h2222_0004, 32'h1111_0004, 32'h0000_0004},
    {1'b1, 32'hFFFF_FFFB, 32'hDDDD_0005, 32'h2222_0005, 32'h1111_0005, 32'h0000_0005},
    {1'b1, 32'hFFFF_FFFC, 32'hDDDD_0006, 32'h2222_0006, 32'h1111_0006, 32'h0000_0006}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, has_data = 1'b0, is_cfg = 1'b0, link_up = 1'b1, ready = 1'b1;
  logic [DW-1:0] h0 = '0, h1 = '0, h2 = '0, dat = '0;
  logic [AW-1:0] addr = '0;
  logic [2*DW-1:0] odata;
  logic ovalid, olast;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlp_qw_packer u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .hdr0_i(h0), .hdr1_i(h1),
    .hdr2_i(h2), .has_data_i(has_data), .data_i(dat), .addr_i(addr),
    .is_cfg_i(is_cfg), .link_up_i(link_up), .ready_i(ready),
    .out_data_o(odata), .out_valid_o(ovalid), .out_last_o(olast)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_word(input int b, input logic [DW-1:0] e0, e1, e2, ed,
                                           input logic hd, input logic [AW-1:0] ad);
    if (b == 0) return {e1, e0};
    if (b == 1) return {(hd && ad[2]) ? ed : 32'h0, e2};
    return {32'h0, ed};
  endfunction

  function automatic int exp_beats(input logic hd, input logic [AW-1:0] ad);
    return (hd && !ad[2]) ? 3 : 2;
  endfunction

  task automatic pulse_start(input logic [DW-1:0] e0, e1, e2, ed, input logic hd,
                             input logic [AW-1:0] ad, input logic cfg);
    h0 = e0; h1 = e1; h2 = e2; dat = ed; has_data = hd; addr = ad; is_cfg = cfg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // expects the first word to be on the outputs now; walks the packet with ready high
  task automatic drain(input logic [DW-1:0] e0, e1, e2, ed, input logic hd,
                       input logic [AW-1:0] ad, input string tag);
    int nb;
    string rq;
    nb = exp_beats(hd, ad);
    for (int b = 0; b < nb; b++) begin
      rq = (b == 0) ? "R1" : (!hd ? "R4" : (ad[2] ? "R2" : "R3"));
      chk({rq, " valid ", tag}, 64'(ovalid), 64'd1);
      chk({rq, " word ", tag}, odata, exp_word(b, e0, e1, e2, ed, hd, ad));
      chk({rq, " last ", tag}, 64'(olast), 64'(b == nb - 1));
      @(negedge clk);
    end
    chk({"R10 valid drops ", tag}, 64'(ovalid), 64'd0);
    chk({"R10 last low ", tag}, 64'(olast), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: valid low during reset
    chk("R9 valid in reset", 64'(ovalid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 valid after release", 64'(ovalid), 64'd0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      pulse_start(v[31:0], v[63:32], v[95:64], v[127:96], v[VW-1], v[159:128], 1'b0);
      drain(v[31:0], v[63:32], v[95:64], v[127:96], v[VW-1], v[159:128], $sformatf("vec%0d", i));
    end

    // R5: same request, differing only outside bit 2, gives the same second word
    pulse_start(32'hA0, 32'hA1, 32'hA2, 32'hAD, 1'b1, 32'h8000_0004, 1'b0);
    @(negedge clk);
    chk("R5 high addr bits ignored", odata, {32'hAD, 32'hA2});
    @(negedge clk);

    // R7: stall on second word of an aligned packet
    pulse_start(32'hB0, 32'hB1, 32'hB2, 32'hBD, 1'b1, 32'h10, 1'b0);
    @(negedge clk);
    ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 stall word", odata, {32'h0, 32'hB2});
      chk("R7 stall valid", 64'(ovalid), 64'd1);
      chk("R7 stall last", 64'(olast), 64'd0);
    end
    ready = 1'b1;
    @(negedge clk);
    chk("R3 after stall", odata, {32'h0, 32'hBD});
    @(negedge clk);
    chk("R10 after stall", 64'(ovalid), 64'd0);

    // R8: start during a packet is ignored
    pulse_start(32'hC0, 32'hC1, 32'hC2, 32'hCD, 1'b1, 32'h0, 1'b0);
    h0 = 32'hEE0; h1 = 32'hEE1; h2 = 32'hEE2; dat = 32'hEED; addr = 32'h4; start = 1'b1;
    chk("R8 word 0 kept", odata, {32'hC1, 32'hC0});
    @(negedge clk);
    chk("R8 word 1 kept", odata, {32'h0, 32'hC2});
    @(negedge clk);
    start = 1'b0;
    chk("R8 word 2 kept", odata, {32'h0, 32'hCD});
    @(negedge clk);
    chk("R8 no extra packet", 64'(ovalid), 64'd0);

    // R6: configuration request held while link down
    link_up = 1'b0;
    pulse_start(32'hF0, 32'hF1, 32'hF2, 32'hFD, 1'b1, 32'h4, 1'b1);
    repeat (4) begin
      chk("R6 held", 64'(ovalid), 64'd0);
      @(negedge clk);
    end
    // R8: start while held is ignored
    h0 = 32'h990; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 still held", 64'(ovalid), 64'd0);
    link_up = 1'b1;
    @(negedge clk);
    drain(32'hF0, 32'hF1, 32'hF2, 32'hFD, 1'b1, 32'h4, "R6 cfg released");

    // R6: non-configuration request not delayed by link down
    link_up = 1'b0;
    pulse_start(32'h50, 32'h51, 32'h52, 32'h5D, 1'b0, 32'h0, 1'b0);
    drain(32'h50, 32'h51, 32'h52, 32'h5D, 1'b0, 32'h0, "R6 non-cfg");
    link_up = 1'b1;

    // R9: reset mid-packet
    pulse_start(32'h60, 32'h61, 32'h62, 32'h6D, 1'b1, 32'h0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid-packet reset", 64'(ovalid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after reset", 64'(ovalid), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule